// File: doc/BRIEF.md
# Configurable Quasi-Bidirectional Port Pin Driver

This block holds the output latch for a group of general-purpose pins and turns it into three pad drive enables per pin: a strong pull-up, a weak pull-up and a pull-down. Each pin picks one of three drive styles with its own mode field. The first is a standard quasi-bidirectional style, with a weak pull-up held while the latch is 1 and a short strong boost on each rising latch edge. The second is open drain, which only ever pulls low. The third is push-pull, which drives both levels and is output-only.

Software writes all latches at once through a write strobe. On reset each latch takes the level given by that pin's reset-select input. The pad level comes back through a two-flop synchronizer as read data. A build parameter selects the variant used on a multiplexed address/data port, where the standard style has no weak pull-up. On that variant a written 1 is only driven during the boost, after which the pin floats and can serve as a high-impedance input.

Top module: `qb_port_drv`

## Requirements
- R1: While `rst_n` is low at a clock edge, each latch bit loads `rst_hi` for that pin (1 = pin starts high, 0 = pin starts low), and no strong boost is pending after reset.
- R2: In standard mode (mode field 2'b00) on the general variant, `pu_weak` equals the latch bit and `pd` equals its inverse.
- R3: In standard mode, a write that takes a latch bit from 0 to 1 turns on `pu_strong` for exactly `BOOST_CYC` (default 2) clock periods, starting with the cycle after the write edge.
- R4: Writing 1 to a latch bit that already holds 1 does not start a new boost.
- R5: Writing 0 to a latch bit ends any boost at once: in the cycle after that write edge, `pd` is on and both pull-ups are off, in every mode.
- R6: In open-drain mode (mode field 2'b01, and also 2'b11), `pd` equals the inverse of the latch bit and neither pull-up is ever enabled.
- R7: In push-pull mode (mode field 2'b10), `pu_strong` equals the latch bit, `pd` its inverse, and `pu_weak` is off.
- R8: `pd` is never enabled in the same cycle as either pull-up on the same pin.
- R9: `rd_data` shows `pad_in` as it was sampled two clock edges earlier (two-flop synchronizer, cleared to 0 by reset).
- R10: With `ADDR_DATA` = 1, standard mode never enables `pu_weak`; a latch 1 is driven only by the boost, after which all three enables of that pin are off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Latch write strobe |
| wr_data | input | NPIN | New latch value, one bit per pin |
| mode | input | 2*NPIN | Per-pin drive style, pin i in bits [2i+1:2i] |
| rst_hi | input | NPIN | Per-pin reset level select (1 = high) |
| pad_in | input | NPIN | Resolved pad level |
| pu_strong | output | NPIN | Strong pull-up enable |
| pu_weak | output | NPIN | Weak pull-up enable |
| pd | output | NPIN | Pull-down enable |
| rd_data | output | NPIN | Synchronized pad level |

## Verification
The assertions watch, on every cycle, that the pull-down never overlaps a pull-up, that open-drain pins never pull up, and that a boost never runs past its length. They also check that a written 0 lands as a pure pull-down on the next cycle and that read data trails the pad by two edges. Only the bench scenarios show the positive behaviour: that a boost starts on a real 0-to-1 edge and not on a rewrite, and that the reset level follows each pin's select. They also show the exact enables in push-pull mode and that the address/data variant floats once the boost ends.

// File: rtl/qb_port_drv.sv
module qb_port_drv #(
  parameter int NPIN      = 8,
  parameter int BOOST_CYC = 2,
  parameter bit ADDR_DATA = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [NPIN-1:0]   wr_data,
  input  logic [2*NPIN-1:0] mode,
  input  logic [NPIN-1:0]   rst_hi,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pu_strong,
  output logic [NPIN-1:0]   pu_weak,
  output logic [NPIN-1:0]   pd,
  output logic [NPIN-1:0]   rd_data
);

  localparam int        CW      = $clog2(BOOST_CYC + 1);
  localparam logic [1:0] M_STD  = 2'b00;
  localparam logic [1:0] M_PP   = 2'b10;
  localparam logic       WEAK_ON = !ADDR_DATA;

  logic [NPIN-1:0] latch_q;
  logic [NPIN-1:0] sync1_q;
  logic [NPIN-1:0] sync2_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     latch_q <= rst_hi;
    else if (wr_en) latch_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  assign rd_data = sync2_q;

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic [CW-1:0] boost_q;
    logic [1:0]    sel;
    logic          rise;

    assign sel  = mode[2*g +: 2];
    assign rise = wr_en && wr_data[g] && !latch_q[g];

    always_ff @(posedge clk) begin
      if (!rst_n)                   boost_q <= '0;
      else if (wr_en && !wr_data[g]) boost_q <= '0;
      else if (rise)                boost_q <= CW'(BOOST_CYC);
      else if (boost_q != '0)       boost_q <= boost_q - CW'(1);
    end

    always_comb begin
      pu_strong[g] = 1'b0;
      pu_weak[g]   = 1'b0;
      pd[g]        = !latch_q[g];
      case (sel)
        M_STD: begin
          pu_strong[g] = latch_q[g] && (boost_q != '0);
          pu_weak[g]   = WEAK_ON && latch_q[g];
        end
        M_PP:    pu_strong[g] = latch_q[g];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/qb_port_drv_chk.sv
module qb_port_drv_chk #(
  parameter int NPIN      = 8,
  parameter int BOOST_CYC = 2,
  parameter bit ADDR_DATA = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [NPIN-1:0]   wr_data,
  input logic [2*NPIN-1:0] mode,
  input logic [NPIN-1:0]   pad_in,
  input logic [NPIN-1:0]   pu_strong,
  input logic [NPIN-1:0]   pu_weak,
  input logic [NPIN-1:0]   pd,
  input logic [NPIN-1:0]   rd_data
);

  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (!rst_n)           age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  p_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2) |-> (rd_data == $past(pad_in, 2)));

  for (genvar g = 0; g < NPIN; g++) begin : g_chk
    logic [1:0] sel;
    logic       std_boost;
    int unsigned run_q;

    assign sel       = mode[2*g +: 2];
    assign std_boost = pu_strong[g] && (sel == 2'b00);

    always_ff @(posedge clk) begin
      if (!rst_n)         run_q <= 0;
      else if (std_boost) run_q <= run_q + 1;
      else                run_q <= 0;
    end

    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pd[g] |-> !(pu_strong[g] || pu_weak[g]));

    p_od_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel[0] == 1'b1) |-> !(pu_strong[g] || pu_weak[g]));

    p_boost_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      std_boost |-> (run_q < BOOST_CYC));

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((age_q != 2'd0) && $past(wr_en && !wr_data[g]))
        |-> (pd[g] && !pu_strong[g] && !pu_weak[g]));

    if (ADDR_DATA) begin : g_ad
      p_noweak_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pu_weak[g]);
    end
  end

endmodule

bind qb_port_drv qb_port_drv_chk #(
  .NPIN(NPIN), .BOOST_CYC(BOOST_CYC), .ADDR_DATA(ADDR_DATA)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .mode(mode),
  .pad_in(pad_in), .pu_strong(pu_strong), .pu_weak(pu_weak), .pd(pd),
  .rd_data(rd_data)
);

// File: tb/test_qb_port_drv.sv
module test_qb_port_drv;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [N-1:0]   wr_data = '0;
  logic [2*N-1:0] mode = '0;
  logic [N-1:0]   rst_hi = 4'b0101;
  logic [N-1:0]   pad_in = '0;
  logic [N-1:0]   s_g, w_g, d_g, r_g;
  logic [N-1:0]   s_a, w_a, d_a, r_a;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  qb_port_drv #(.NPIN(N), .BOOST_CYC(2), .ADDR_DATA(1'b0)) i_qb_port_drv (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .mode(mode),
    .rst_hi(rst_hi), .pad_in(pad_in), .pu_strong(s_g), .pu_weak(w_g),
    .pd(d_g), .rd_data(r_g));

  qb_port_drv #(.NPIN(N), .BOOST_CYC(2), .ADDR_DATA(1'b1)) i_qb_port_drv_ad (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .mode(mode),
    .rst_hi(rst_hi), .pad_in(pad_in), .pu_strong(s_a), .pu_weak(w_a),
    .pd(d_a), .rd_data(r_a));

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chk_gen(input string req, input logic [N-1:0] es, input logic [N-1:0] ew, input logic [N-1:0] ed);
    chk({req, " strong"}, s_g, es);
    chk({req, " weak"}, w_g, ew);
    chk({req, " pd"}, d_g, ed);
    chk("R8 overlap", d_g & (s_g | w_g), '0);
  endtask

  task automatic write(input logic [N-1:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    mode = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk_gen("R1 reset", 4'b0000, 4'b0101, 4'b1010);
    chk("R1 ad reset weak", w_a, 4'b0000);
    chk("R9 reset rd", r_g, 4'b0000);
  endtask

  task automatic t_boost();
    mode = '0;
    write(4'b1111);
    chk_gen("R3 boost c1", 4'b1010, 4'b1111, 4'b0000);
    step();
    chk_gen("R3 boost c2", 4'b1010, 4'b1111, 4'b0000);
    step();
    chk_gen("R3 boost end", 4'b0000, 4'b1111, 4'b0000);
    chk_gen("R2 standard high", 4'b0000, 4'b1111, 4'b0000);
  endtask

  task automatic t_rewrite();
    write(4'b1111);
    chk_gen("R4 rewrite c1", 4'b0000, 4'b1111, 4'b0000);
    step();
    chk_gen("R4 rewrite c2", 4'b0000, 4'b1111, 4'b0000);
  endtask

  task automatic t_cut();
    write(4'b0000);
    chk_gen("R2 standard low", 4'b0000, 4'b0000, 4'b1111);
    write(4'b1111);
    chk_gen("R5 boost on", 4'b1111, 4'b1111, 4'b0000);
    wr_en = 1'b1;
    wr_data = 4'b0011;
    step();
    wr_en = 1'b0;
    chk_gen("R5 cut", 4'b0011, 4'b0011, 4'b1100);
    step();
    chk_gen("R5 after", 4'b0000, 4'b0011, 4'b1100);
  endtask

  task automatic t_open_drain();
    mode = 8'b11_01_11_01;
    write(4'b0110);
    chk_gen("R6 od", 4'b0000, 4'b0000, 4'b1001);
    write(4'b1111);
    chk_gen("R6 od high", 4'b0000, 4'b0000, 4'b0000);
  endtask

  task automatic t_push_pull();
    mode = 8'b10_10_10_10;
    write(4'b1010);
    chk_gen("R7 pp", 4'b1010, 4'b0000, 4'b0101);
    step();
    step();
    chk_gen("R7 pp hold", 4'b1010, 4'b0000, 4'b0101);
  endtask

  task automatic t_sync();
    @(negedge clk);
    pad_in = 4'b1001;
    @(negedge clk);
    chk("R9 one edge", r_g, 4'b0000);
    @(negedge clk);
    chk("R9 two edges", r_g, 4'b1001);
    pad_in = 4'b0110;
    step();
    step();
    chk("R9 second", r_g, 4'b0110);
  endtask

  task automatic t_addr_data();
    mode = '0;
    write(4'b0000);
    chk("R10 low pd", d_a, 4'b1111);
    write(4'b1111);
    chk("R10 boost c1", s_a, 4'b1111);
    chk("R10 weak off", w_a, 4'b0000);
    step();
    chk("R10 boost c2", s_a, 4'b1111);
    step();
    chk("R10 float strong", s_a, 4'b0000);
    chk("R10 float weak", w_a, 4'b0000);
    chk("R10 float pd", d_a, 4'b0000);
  endtask

  task automatic t_reset_sel();
    rst_hi = 4'b1100;
    rst_n = 1'b0;
    repeat (2) step();
    rst_n = 1'b1;
    mode = '0;
    step();
    chk_gen("R1 reselect", 4'b0000, 4'b1100, 4'b0011);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_boost();
    t_rewrite();
    t_cut();
    t_open_drain();
    t_push_pull();
    t_sync();
    t_addr_data();
    t_reset_sel();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule